// File: doc/BRIEF.md
# Five-Source Interrupt Request Controller

This block collects interrupt requests for a small 8-bit processor core and hands them to the core one at a time. It watches two active-low external request pins, two timer overflow pulses and the receive-done and transmit-done pulses of a serial port. Each of these keeps a request flag. Each external pin can be set to one of two trigger modes. In falling-edge mode a detected edge latches the flag. In low-level mode the flag simply mirrors the pin.

The receive and transmit flags together form one serial source, so there are five sources in all. A source is offered to the core only when three things hold: its flag is set, its own enable bit is set, and the global enable is set. When several sources qualify, a fixed priority picks one. The core sees a registered pending line and a 3-bit vector index. It accepts a request by pulsing `irq_ack` while pending is high. Software can overwrite the flags with a write strobe and a data word, and the flags are always readable on an output.

Top module: `irq_ctrl5`

## Requirements
- R1: After reset, `flags` is 0, `irq_pend` is 0 and `irq_vec` is 0.
- R2: When `ext_edge[k]` is 1, a high-to-low change on `ext_n[k]` sets the flag for that pin three clock edges after the change. The flag for pin 0 is `flags[0]` and the flag for pin 1 is `flags[2]`. Because each pin passes through two synchronizer stages, a low pulse must last at least one clock to be seen. Once set, the flag stays set after the pin returns high.
- R3: When `ext_edge[k]` is 0, the flag for that pin equals the inverse of the pin as seen after two synchronizer stages. The flag is not latched. Software writes and acknowledges do not change it.
- R4: A one-cycle high on `tmr_ovf[0]` sets `flags[1]`, and a one-cycle high on `tmr_ovf[1]` sets `flags[3]`, at the next clock edge.
- R5: `rx_done` sets `flags[4]` and `tx_done` sets `flags[5]` at the next clock edge. Either flag alone requests the serial source.
- R6: A source raises `irq_pend` only if its flag, its bit in `src_en` and `glb_en` are all 1. The `src_en` bits are: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial.
- R7: When several sources qualify, the fixed priority is external 0 > timer 0 > external 1 > timer 1 > serial. `irq_vec` gives the winner as 0, 1, 2, 3 or 4 respectively.
- R8: `irq_pend` and `irq_vec` are registered from the flags of the previous cycle. In the cycle after an accepted acknowledge (`irq_ack` high while `irq_pend` is high), `irq_pend` is 0.
- R9: An accepted acknowledge clears the flag of the acknowledged vector if that vector is a timer or an edge-mode external pin. It never clears `flags[4]` or `flags[5]`.
- R10: When `flag_wr` is 1, every non-level flag takes the value of `flag_wdata` at the next edge. A hardware set event in the same cycle still sets its flag. The write takes precedence over an acknowledge clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_n | input | 2 | Active-low external request pins |
| ext_edge | input | 2 | Per-pin trigger mode: 1 falling edge, 0 low level |
| tmr_ovf | input | 2 | Timer overflow pulses |
| rx_done | input | 1 | Serial receive-complete pulse |
| tx_done | input | 1 | Serial transmit-complete pulse |
| src_en | input | 5 | Per-source enables |
| glb_en | input | 1 | Global enable |
| flag_wr | input | 1 | Software flag write strobe |
| flag_wdata | input | 6 | Flag value to write |
| flags | output | 6 | Current request flags |
| irq_ack | input | 1 | Core accepts the pending request |
| irq_pend | output | 1 | A request is offered to the core |
| irq_vec | output | 3 | Vector index of the offered request |

## Verification
The bench targets four kinds of corner case.

- An acknowledge arriving while a serial flag is set: a design that clears the serial flag on acknowledge would lose the transmit or receive event.
- A pin held low in level mode while software writes zeros: a design that latches level requests would keep the flag after the pin rises.
- A timer pulse landing in the same cycle as a software clear: if the write were allowed to win, that overflow would be silently dropped.
- Every source pending at once, acknowledged in turn: a wrong priority order or a stale pending line in the cycle after an acknowledge would show up as wrong vectors or a double dispatch.

// File: rtl/irq_ctrl5.sv
module irq_ctrl5 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ext_n,
  input  logic [1:0] ext_edge,
  input  logic [1:0] tmr_ovf,
  input  logic       rx_done,
  input  logic       tx_done,
  input  logic [4:0] src_en,
  input  logic       glb_en,
  input  logic       flag_wr,
  input  logic [5:0] flag_wdata,
  output logic [5:0] flags,
  input  logic       irq_ack,
  output logic       irq_pend,
  output logic [2:0] irq_vec
);
  logic [1:0] sy1, sy2, sy3;
  logic [5:0] set_ev, clr_ev, nxt;
  logic [4:0] req;
  logic [2:0] vec_n;

  wire [1:0] fall   = sy3 & ~sy2;
  wire       ack_ok = irq_ack & irq_pend;

  assign set_ev = {tx_done, rx_done, tmr_ovf[1], fall[1] & ext_edge[1],
                   tmr_ovf[0], fall[0] & ext_edge[0]};

  always_comb begin
    clr_ev = '0;
    if (ack_ok) begin
      case (irq_vec)
        3'd0: clr_ev[0] = 1'b1;
        3'd1: clr_ev[1] = 1'b1;
        3'd2: clr_ev[2] = 1'b1;
        3'd3: clr_ev[3] = 1'b1;
        default: clr_ev = '0;
      endcase
    end
  end

  always_comb begin
    nxt = (flag_wr ? flag_wdata : (flags & ~clr_ev)) | set_ev;
    if (!ext_edge[0]) nxt[0] = ~sy2[0];
    if (!ext_edge[1]) nxt[2] = ~sy2[1];
  end

  assign req = {flags[5] | flags[4], flags[3:0]} & src_en & {5{glb_en}};

  always_comb begin
    vec_n = 3'd0;
    for (int i = 4; i >= 0; i--)
      if (req[i]) vec_n = 3'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1      <= 2'b11;
      sy2      <= 2'b11;
      sy3      <= 2'b11;
      flags    <= '0;
      irq_pend <= 1'b0;
      irq_vec  <= 3'd0;
    end else begin
      sy1      <= ext_n;
      sy2      <= sy1;
      sy3      <= sy2;
      flags    <= nxt;
      irq_pend <= (|req) & ~ack_ok;
      irq_vec  <= vec_n;
    end
  end

  // R8
  pend_drop_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_pend) |=> !irq_pend);

  // R6
  global_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> !irq_pend);

  // R4
  timer0_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf[0] |=> flags[1]);

  // R9
  serial_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[4] && !flag_wr) |=> flags[4]);

  // R7
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pend |-> (irq_vec <= 3'd4));

  // R2
  edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_edge[0] && flags[0] && !flag_wr && !(irq_ack && irq_pend && irq_vec == 3'd0))
      |=> (flags[0] || !ext_edge[0]));
endmodule

// File: tb/irq_ctrl5_test.sv
`timescale 1ns/1ps
module irq_ctrl5_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] ext_n, ext_edge, tmr_ovf;
  logic       rx_done, tx_done, glb_en, flag_wr, irq_ack;
  logic [4:0] src_en;
  logic [5:0] flag_wdata;
  logic [5:0] flags;
  logic       irq_pend;
  logic [2:0] irq_vec;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [1:0] m_s1, m_s2, m_s3;
  logic [5:0] m_flags;
  logic       m_pend;
  logic [2:0] m_vec;

  always #4 clk = ~clk;

  irq_ctrl5 uut (.clk(clk), .rst_n(rst_n), .ext_n(ext_n), .ext_edge(ext_edge),
    .tmr_ovf(tmr_ovf), .rx_done(rx_done), .tx_done(tx_done), .src_en(src_en),
    .glb_en(glb_en), .flag_wr(flag_wr), .flag_wdata(flag_wdata), .flags(flags),
    .irq_ack(irq_ack), .irq_pend(irq_pend), .irq_vec(irq_vec));

  function automatic logic [2:0] pick(input logic [4:0] r);
    for (int i = 0; i < 5; i++) if (r[i]) return 3'(i);
    return 3'd0;
  endfunction

  function automatic logic [4:0] requests(input logic [5:0] f, input logic [4:0] en, input logic g);
    return {f[5] | f[4], f[3:0]} & en & {5{g}};
  endfunction

  task automatic model_step();
    logic [1:0] fl;
    logic acc;
    logic [5:0] nf;
    logic [4:0] r;
    fl = m_s3 & ~m_s2;
    acc = irq_ack & m_pend;
    nf = flag_wr ? flag_wdata : m_flags;
    if (!flag_wr && acc) begin
      if (m_vec == 3'd0) nf[0] = 1'b0;
      if (m_vec == 3'd1) nf[1] = 1'b0;
      if (m_vec == 3'd2) nf[2] = 1'b0;
      if (m_vec == 3'd3) nf[3] = 1'b0;
    end
    if (ext_edge[0] && fl[0]) nf[0] = 1'b1;
    if (ext_edge[1] && fl[1]) nf[2] = 1'b1;
    if (tmr_ovf[0]) nf[1] = 1'b1;
    if (tmr_ovf[1]) nf[3] = 1'b1;
    if (rx_done) nf[4] = 1'b1;
    if (tx_done) nf[5] = 1'b1;
    if (!ext_edge[0]) nf[0] = ~m_s2[0];
    if (!ext_edge[1]) nf[2] = ~m_s2[1];
    r = requests(m_flags, src_en, glb_en);
    m_pend  = (|r) & ~acc;
    m_vec   = pick(r);
    m_flags = nf;
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_n;
  endtask

  task automatic check(input string tag);
    n_chk++;
    if (flags !== m_flags || irq_pend !== m_pend || irq_vec !== m_vec) begin
      n_bad++;
      $display("FAIL %s: flags=%h pend=%b vec=%0d, expected flags=%h pend=%b vec=%0d",
               tag, flags, irq_pend, irq_vec, m_flags, m_pend, m_vec);
    end
  endtask

  task automatic tick(input string tag);
    model_step();
    @(negedge clk);
    check(tag);
  endtask

  task automatic quiet();
    tmr_ovf = 0; rx_done = 0; tx_done = 0; flag_wr = 0; irq_ack = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; ext_n = 2'b11; ext_edge = 2'b11; quiet(); flag_wdata = 0;
    src_en = 5'h1F; glb_en = 1;
    m_s1 = 2'b11; m_s2 = 2'b11; m_s3 = 2'b11; m_flags = 0; m_pend = 0; m_vec = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 reset");

    // R4 timer pulses
    tmr_ovf = 2'b01; tick("R4");
    quiet(); tick("R4"); tick("R4");
    tmr_ovf = 2'b10; tick("R4");
    quiet(); tick("R4");

    // R10 write clears, same-cycle timer set wins
    flag_wr = 1; flag_wdata = 0; tmr_ovf = 2'b01; tick("R10");
    quiet(); tick("R10");
    flag_wr = 1; flag_wdata = 0; tick("R10"); quiet(); tick("R10");

    // R5 serial flags
    rx_done = 1; tick("R5"); quiet(); tick("R5");
    flag_wr = 1; flag_wdata = 0; tick("R5"); quiet();
    tx_done = 1; tick("R5"); quiet(); tick("R5"); tick("R5");

    // R7 / R9 all pending, acknowledge in turn
    flag_wr = 1; flag_wdata = 6'h3F; tick("R7"); quiet(); tick("R7");
    for (int k = 0; k < 7; k++) begin
      irq_ack = irq_pend; tick("R9"); irq_ack = 0; tick("R8");
    end
    tick("R9");

    // R6 gating
    flag_wr = 1; flag_wdata = 6'h0F; tick("R6"); quiet();
    glb_en = 0; tick("R6"); tick("R6");
    glb_en = 1; src_en = 5'b01010; tick("R6"); tick("R6");
    src_en = 5'h1F; tick("R6");
    flag_wr = 1; flag_wdata = 0; tick("R6"); quiet(); tick("R6");

    // R2 edge trigger on pin 1
    ext_n = 2'b01; tick("R2"); ext_n = 2'b11;
    for (int k = 0; k < 5; k++) tick("R2");

    // R3 level trigger on pin 0, write cannot clear
    ext_edge = 2'b10; ext_n = 2'b10;
    for (int k = 0; k < 4; k++) tick("R3");
    flag_wr = 1; flag_wdata = 0; tick("R3"); quiet();
    irq_ack = irq_pend; tick("R3"); irq_ack = 0;
    ext_n = 2'b11;
    for (int k = 0; k < 4; k++) tick("R3");

    // randomized mix
    for (int k = 0; k < 6000; k++) begin
      if (($urandom % 64) == 0) ext_edge = 2'($urandom);
      if (($urandom % 4) == 0) ext_n = 2'($urandom);
      tmr_ovf = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
      rx_done = (($urandom % 16) == 0);
      tx_done = (($urandom % 16) == 0);
      src_en  = (($urandom % 32) == 0) ? 5'($urandom) : src_en;
      glb_en  = (($urandom % 20) != 0);
      flag_wr = (($urandom % 16) == 0);
      flag_wdata = 6'($urandom);
      irq_ack = (($urandom % 2) == 0);
      tick("random mix");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule